// File: doc/BRIEF.md
# Flag Threshold Offset Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Software or a host controller writes them on the write clock in one of two ways. Parallel writes take one word from the data bus per edge and alternate between the two offsets. Serial writes shift one bit per edge into the chained pair. Any offset can be read back word by word on the read clock. The block also blocks the FIFO's own write and read strobes while an offset access is in progress, so that no data word is stored or consumed.

A master reset loads both offsets with one of two defaults, 127 or 1023, chosen by a level input. A partial reset leaves both offsets untouched and only sends the parallel-access selectors back to the almost-empty offset. The read-clock copy of the offsets is refreshed through a four-phase request/acknowledge handshake. Both offsets of a pair therefore change together in the read domain, and never partway through a comparison.

The write-domain transfer machine has three states. HS_IDLE moves to HS_REQ when a change is pending, and the shadow pair is captured on that move. HS_REQ moves to HS_REL once the synchronized acknowledge is seen high. HS_REL moves back to HS_IDLE once the acknowledge is seen low. The read-domain receiver has two states. RX_IDLE moves to RX_HOLD on a synchronized request and copies the shadow pair into the read-domain outputs. RX_HOLD returns to RX_IDLE when the request drops. The write-side operation decode yields OP_NONE, OP_PAR or OP_SER on each edge.

Top module: `flag_ofs_loader`

## Requirements
- R1: While `mrst_n` is low, all four offset outputs equal 127 if `dflt_hi` is 0, or 1023 if `dflt_hi` is 1. `rd_data` is 0, and both access selectors point to the almost-empty offset.
- R2: A write-clock edge with `ld`=1 and `wen`=1 stores `din` into the almost-empty offset if the write selector is 0, or into the almost-full offset if it is 1. The selector then flips.
- R3: A write-clock edge with `ld`=1, `sen`=1 and `wen`=0 shifts the pair {almost-full, almost-empty} right by one bit, with `si` entering the top bit of the almost-full offset. After 2*OW such edges, the first bit sent sits in bit 0 of the almost-empty offset and the last sent sits in the top bit of the almost-full offset.
- R4: On a write-clock edge without `ld`=1 together with `wen` or `sen`, both write-domain offsets keep their values.
- R5: `fifo_wr_en` equals `wen` and not `ld`; `fifo_rd_en` equals `ren` and not `ld`.
- R6: A read-clock edge with `ld`=1 and `ren`=1 loads `rd_data` with the read-domain almost-empty offset if the read selector is 0, or the almost-full offset if it is 1. The selector then flips. On any other read edge, `rd_data` holds its value.
- R7: A clock edge with `prst_n` low returns the selector of that clock domain to 0. It changes neither offset in either domain.
- R8: Within 40 write-clock cycles after the last offset change, `ae_off_r` and `af_off_r` equal the write-domain values. They change only as a pair, taken from a shadow that is held still while the request is up.
- R9: When `ld`, `wen` and `sen` are all 1 on one edge, only the parallel write of R2 takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, sampled on each clock |
| dflt_hi | input | 1 | Default choice at master reset: 0 gives 127, 1 gives 1023 |
| ld | input | 1 | Offset access select |
| wen | input | 1 | Write strobe; a parallel offset write when `ld` is high |
| sen | input | 1 | Serial shift strobe, used when `ld` is high |
| si | input | 1 | Serial offset bit |
| din | input | OW | Parallel offset word |
| ren | input | 1 | Read strobe; an offset read-back when `ld` is high |
| fifo_wr_en | output | 1 | Write strobe passed to the FIFO storage |
| fifo_rd_en | output | 1 | Read strobe passed to the FIFO storage |
| ae_off_w | output | OW | Almost-empty offset, write domain |
| af_off_w | output | OW | Almost-full offset, write domain |
| ae_off_r | output | OW | Almost-empty offset, read domain |
| af_off_r | output | OW | Almost-full offset, read domain |
| rd_data | output | OW | Offset read-back word |

## Verification
The strobe gating of R5 is combinational, so it is sampled 1 ns after the inputs change and before the next write edge. The write-domain offsets (R2, R3, R4, R9) and `rd_data` (R6) change on the first edge of their own clock, so each is sampled on the falling edge that follows. The strobes are dropped just after the rising edge so that an access never repeats. The read-domain copies pass through two synchronizer stages in each direction plus one capture edge, about ten write cycles in all. The bench waits 40 write cycles after the last change before it compares them (R8), and it performs read-back only after such a wait.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_REL  = 2'd2
    } hs_state_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_t;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PAR  = 2'd1,
        OP_SER  = 2'd2
    } ld_op_t;

    function automatic ofs_sel_t sel_flip(input ofs_sel_t s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

endpackage

// File: rtl/ofs_sync.sv
module ofs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ofs_wr_regs.sv
module ofs_wr_regs
    import ofs_pkg::*;
#(
    parameter int OW      = 16,
    parameter int DFLT_LO = 127,
    parameter int DFLT_HI = 1023
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          dflt_hi,
    input  logic          ld,
    input  logic          wen,
    input  logic          sen,
    input  logic          si,
    input  logic [OW-1:0] din,
    output logic [OW-1:0] ae_q,
    output logic [OW-1:0] af_q,
    output logic          chg
);
    localparam logic [OW-1:0] LO_V = OW'(DFLT_LO);
    localparam logic [OW-1:0] HI_V = OW'(DFLT_HI);

    ld_op_t   op;
    ofs_sel_t wsel;
    logic [OW-1:0] ae_r, af_r;

    // operation decode: parallel has priority over serial
    always_comb begin
        op = OP_NONE;
        if (ld && wen)      op = OP_PAR;
        else if (ld && sen) op = OP_SER;
    end

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            ae_r <= dflt_hi ? HI_V : LO_V;
            af_r <= dflt_hi ? HI_V : LO_V;
            chg  <= 1'b0;
        end else begin
            unique case (op)
                OP_PAR: begin
                    if (wsel == SEL_AE) ae_r <= din;
                    else                af_r <= din;
                end
                OP_SER:  {af_r, ae_r} <= {si, af_r, ae_r[OW-1:1]};
                default: ;
            endcase
            chg <= (op != OP_NONE);
        end
    end

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n)             wsel <= SEL_AE;
        else if (!prst_n)        wsel <= SEL_AE;
        else if (op == OP_PAR)   wsel <= sel_flip(wsel);
    end

    assign ae_q = ae_r;
    assign af_q = af_r;

    // R4
    wr_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !(ld && (wen || sen)) |=> $stable({af_q, ae_q}));

    // R2
    par_ae_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (ld && wen && wsel == SEL_AE) |=> (ae_q == $past(din)));

    // R3
    ser_shift_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (ld && sen && !wen) |=> (af_q[OW-1] == $past(si)));
endmodule

// File: rtl/ofs_xfer_tx.sv
module ofs_xfer_tx
    import ofs_pkg::*;
#(
    parameter int OW     = 16,
    parameter int STAGES = 2
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          chg,
    input  logic [OW-1:0] ae_q,
    input  logic [OW-1:0] af_q,
    input  logic          ack_in,
    output logic          req,
    output logic [OW-1:0] sh_ae,
    output logic [OW-1:0] sh_af
);
    hs_state_t st, nxt;
    logic ack_s, dirty, cap;

    ofs_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(wclk), .rst_n(mrst_n), .d(ack_in), .q(ack_s)
    );

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) st <= HS_IDLE;
        else         st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            HS_IDLE: if (dirty)  nxt = HS_REQ;
            HS_REQ:  if (ack_s)  nxt = HS_REL;
            HS_REL:  if (!ack_s) nxt = HS_IDLE;
            default: nxt = HS_IDLE;
        endcase
    end

    always_comb begin
        req = (st == HS_REQ);
        cap = (st == HS_IDLE) && dirty;
    end

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            dirty <= 1'b0;
            sh_ae <= '0;
            sh_af <= '0;
        end else begin
            dirty <= chg || (dirty && !cap);
            if (cap) begin
                sh_ae <= ae_q;
                sh_af <= af_q;
            end
        end
    end

    // R8
    shadow_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (st == HS_REQ) |=> $stable({sh_af, sh_ae}));
endmodule

// File: rtl/ofs_xfer_rx.sv
module ofs_xfer_rx
    import ofs_pkg::*;
#(
    parameter int OW      = 16,
    parameter int STAGES  = 2,
    parameter int DFLT_LO = 127,
    parameter int DFLT_HI = 1023
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          dflt_hi,
    input  logic          req_in,
    input  logic [OW-1:0] sh_ae,
    input  logic [OW-1:0] sh_af,
    output logic          ack,
    output logic [OW-1:0] ae_r,
    output logic [OW-1:0] af_r
);
    localparam logic [OW-1:0] LO_V = OW'(DFLT_LO);
    localparam logic [OW-1:0] HI_V = OW'(DFLT_HI);

    rx_state_t st, nxt;
    logic req_s;

    ofs_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(rclk), .rst_n(mrst_n), .d(req_in), .q(req_s)
    );

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) st <= RX_IDLE;
        else         st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE: if (req_s)  nxt = RX_HOLD;
            RX_HOLD: if (!req_s) nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    always_comb ack = (st == RX_HOLD);

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            ae_r <= dflt_hi ? HI_V : LO_V;
            af_r <= dflt_hi ? HI_V : LO_V;
        end else if (st == RX_IDLE && req_s) begin
            ae_r <= sh_ae;
            af_r <= sh_af;
        end
    end

    // R8
    copy_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (st == RX_HOLD) |=> $stable({af_r, ae_r}));
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int OW = 16
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          ld,
    input  logic          ren,
    input  logic [OW-1:0] ae_r,
    input  logic [OW-1:0] af_r,
    output logic [OW-1:0] rd_data
);
    ofs_sel_t rsel;
    logic     hit;

    always_comb hit = ld && ren;

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n)    rd_data <= '0;
        else if (hit)   rd_data <= (rsel == SEL_AE) ? ae_r : af_r;
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n)      rsel <= SEL_AE;
        else if (!prst_n) rsel <= SEL_AE;
        else if (hit)     rsel <= sel_flip(rsel);
    end

    // R6
    rd_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        !(ld && ren) |=> $stable(rd_data));

    // R6
    rd_flip_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (ld && ren && prst_n) |=> (rsel != $past(rsel)));
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
    parameter int OW      = 16,
    parameter int STAGES  = 2,
    parameter int DFLT_LO = 127,
    parameter int DFLT_HI = 1023
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          dflt_hi,
    input  logic          ld,
    input  logic          wen,
    input  logic          sen,
    input  logic          si,
    input  logic [OW-1:0] din,
    input  logic          ren,
    output logic          fifo_wr_en,
    output logic          fifo_rd_en,
    output logic [OW-1:0] ae_off_w,
    output logic [OW-1:0] af_off_w,
    output logic [OW-1:0] ae_off_r,
    output logic [OW-1:0] af_off_r,
    output logic [OW-1:0] rd_data
);
    logic          chg, req, ack;
    logic [OW-1:0] sh_ae, sh_af;

    assign fifo_wr_en = wen && !ld;
    assign fifo_rd_en = ren && !ld;

    ofs_wr_regs #(.OW(OW), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)) u_wr (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .dflt_hi(dflt_hi),
        .ld(ld), .wen(wen), .sen(sen), .si(si), .din(din),
        .ae_q(ae_off_w), .af_q(af_off_w), .chg(chg)
    );

    ofs_xfer_tx #(.OW(OW), .STAGES(STAGES)) u_tx (
        .wclk(wclk), .mrst_n(mrst_n), .chg(chg),
        .ae_q(ae_off_w), .af_q(af_off_w), .ack_in(ack),
        .req(req), .sh_ae(sh_ae), .sh_af(sh_af)
    );

    ofs_xfer_rx #(.OW(OW), .STAGES(STAGES), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)) u_rx (
        .rclk(rclk), .mrst_n(mrst_n), .dflt_hi(dflt_hi), .req_in(req),
        .sh_ae(sh_ae), .sh_af(sh_af), .ack(ack),
        .ae_r(ae_off_r), .af_r(af_off_r)
    );

    ofs_readback #(.OW(OW)) u_rb (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .ren(ren),
        .ae_r(ae_off_r), .af_r(af_off_r), .rd_data(rd_data)
    );

    // R5
    wr_block_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        ld |-> !fifo_wr_en);
endmodule

// File: tb/sim_flag_ofs_loader.sv
module sim_flag_ofs_loader;
    localparam int W = 16;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, dflt_hi = 1'b0;
    logic ld = 1'b0, wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
    logic [W-1:0] din = '0;
    logic fifo_wr_en, fifo_rd_en;
    logic [W-1:0] ae_off_w, af_off_w, ae_off_r, af_off_r, rd_data;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] m_ae, m_af, m_rd;
    logic m_wt, m_rt;

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    flag_ofs_loader #(.OW(W)) u0 (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .dflt_hi(dflt_hi), .ld(ld), .wen(wen), .sen(sen), .si(si), .din(din),
        .ren(ren), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en),
        .ae_off_w(ae_off_w), .af_off_w(af_off_w), .ae_off_r(ae_off_r),
        .af_off_r(af_off_r), .rd_data(rd_data)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [W-1:0] dflt(input logic h);
        return h ? W'(1023) : W'(127);
    endfunction

    task automatic do_mrst(input logic h);
        @(negedge wclk);
        mrst_n = 1'b0; dflt_hi = h;
        #23;
        chk("R1 ae_w", ae_off_w, dflt(h));
        chk("R1 af_w", af_off_w, dflt(h));
        chk("R1 ae_r", ae_off_r, dflt(h));
        chk("R1 af_r", af_off_r, dflt(h));
        chk("R1 rd_data", rd_data, 0);
        @(negedge wclk);
        mrst_n = 1'b1;
        m_ae = dflt(h); m_af = dflt(h); m_rd = '0; m_wt = 1'b0; m_rt = 1'b0;
        repeat (3) @(negedge wclk);
    endtask

    task automatic wr_op(input logic l, input logic w, input logic s,
                         input logic b, input logic [W-1:0] d, input string rq);
        @(negedge wclk);
        ld = l; wen = w; sen = s; si = b; din = d;
        #1;
        chk("R5 fifo_wr_en", fifo_wr_en, w & ~l);
        if (l && w) begin
            if (!m_wt) m_ae = d; else m_af = d;
            m_wt = ~m_wt;
        end else if (l && s) begin
            {m_af, m_ae} = {b, m_af, m_ae[W-1:1]};
        end
        @(posedge wclk);
        #1;
        ld = 1'b0; wen = 1'b0; sen = 1'b0;
        @(negedge wclk);
        chk({rq, " ae_w"}, ae_off_w, m_ae);
        chk({rq, " af_w"}, af_off_w, m_af);
    endtask

    task automatic rd_op(input logic l, input logic r);
        @(negedge rclk);
        ld = l; ren = r;
        #1;
        chk("R5 fifo_rd_en", fifo_rd_en, r & ~l);
        if (l && r) begin
            m_rd = m_rt ? m_af : m_ae;
            m_rt = ~m_rt;
        end
        @(posedge rclk);
        #1;
        ld = 1'b0; ren = 1'b0;
        @(negedge rclk);
        chk("R6 rd_data", rd_data, m_rd);
    endtask

    task automatic settle();
        repeat (40) @(negedge wclk);
        chk("R8 ae_r", ae_off_r, m_ae);
        chk("R8 af_r", af_off_r, m_af);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [2*W-1:0] pat;
        void'($urandom(32'd4242));
        m_ae = '0; m_af = '0; m_rd = '0; m_wt = 1'b0; m_rt = 1'b0;

        // R1: low default
        do_mrst(1'b0);
        rd_op(1'b1, 1'b1);
        rd_op(1'b1, 1'b1);

        // R2: alternate parallel writes
        wr_op(1'b1, 1'b1, 1'b0, 1'b0, 16'h0011, "R2");
        wr_op(1'b1, 1'b1, 1'b0, 1'b0, 16'h2222, "R2");
        settle();
        rd_op(1'b1, 1'b1);
        rd_op(1'b1, 1'b1);

        // R4: no load, or load with no strobe
        wr_op(1'b0, 1'b1, 1'b0, 1'b0, 16'hdead, "R4");
        wr_op(1'b1, 1'b0, 1'b0, 1'b1, 16'hbeef, "R4");
        wr_op(1'b0, 1'b0, 1'b1, 1'b1, 16'hbeef, "R4");

        // R3: full serial load, first bit to AE bit 0
        pat = 32'h9C3A_51E6;
        for (int i = 0; i < 2*W; i++)
            wr_op(1'b1, 1'b0, 1'b1, pat[i], '0, "R3");
        chk("R3 ae pattern", ae_off_w, pat[W-1:0]);
        chk("R3 af pattern", af_off_w, pat[2*W-1:W]);
        settle();

        // R9: both strobes -> parallel only
        wr_op(1'b1, 1'b1, 1'b1, 1'b1, 16'h7777, "R9");
        settle();

        // R7: partial reset keeps offsets, resets selectors
        rd_op(1'b1, 1'b1);
        @(negedge wclk);
        prst_n = 1'b0;
        repeat (4) @(negedge wclk);
        prst_n = 1'b1;
        m_wt = 1'b0; m_rt = 1'b0;
        chk("R7 ae_w", ae_off_w, m_ae);
        chk("R7 af_w", af_off_w, m_af);
        chk("R7 ae_r", ae_off_r, m_ae);
        chk("R7 af_r", af_off_r, m_af);
        wr_op(1'b1, 1'b1, 1'b0, 1'b0, 16'h0abc, "R7 sel");
        settle();
        rd_op(1'b1, 1'b1);

        // random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r < 3)      wr_op(1'b1, 1'b1, 1'b0, 1'b0, W'($urandom), "R2");
            else if (r < 6) wr_op(1'b1, 1'b0, 1'b1, 1'($urandom), '0, "R3");
            else if (r == 6) wr_op(1'b1, 1'b1, 1'b1, 1'($urandom), W'($urandom), "R9");
            else            wr_op(1'($urandom), 1'b0, 1'b0, 1'($urandom), W'($urandom), "R4");
        end
        settle();
        for (int k = 0; k < 40; k++)
            rd_op(1'($urandom), 1'($urandom));

        // R1: high default
        do_mrst(1'b1);
        rd_op(1'b1, 1'b1);
        rd_op(1'b1, 1'b1);

        finish_run();
    end
endmodule